// File: doc/BRIEF.md
# Per-stream block arrival timestamp logger

This block shows how a host spreads its traffic over several downstream application streams. Six input streams deliver beats, and each beat carries a byte-valid strobe for every byte lane. The block never pushes back on any stream and throws the payload away. It keeps a running byte total for each stream. Each time a stream's total passes another 1024-byte boundary, the block captures the value of a shared free-running cycle counter.

Every capture becomes one 32-bit record that holds the stream number and the captured time. All records are merged into a single outgoing record stream with a valid/ready handshake, so they can be returned to the host. From the merged records the host can work out the gaps between blocks for each stream and for all streams together. The inputs are never stalled. When the record queue is full, a new record is discarded and a sticky flag is raised.

Top module: `pkt_stamp_logger`

## Requirements
- R1: `s_ready` is all ones at all times, so no input stream is ever stalled.
- R2: The internal timestamp is 0 during reset and increases by exactly 1 on every clock edge after reset, wrapping silently at 29 bits. A record's stamp is therefore the number of edges from reset release to the completing beat, modulo 2^29.
- R3: A beat adds the number of set strobe bits in its lane of `s_keep` (bits s*8 to s*8+7 for stream s) to that stream's byte total. Strobe bits on a stream whose `s_valid` bit is low are ignored.
- R4: A stream produces exactly one event on the beat that brings its total to 1024 or more. The part beyond 1024 is kept as the starting total of the next block.
- R5: Each record has the stream number in bits [31:29] and, in bits [28:0], the timestamp value present in the cycle the completing beat was accepted.
- R6: When several streams complete a block in the same cycle, their records leave in ascending stream-number order. Each record keeps its own capture time.
- R7: When nothing overflows, every event yields exactly one record, and the records of any one stream appear in the order of their events.
- R8: A record that reaches a full 16-entry queue, or an event that arrives while its stream's previous event is still waiting, is dropped. `overflow` then goes high and stays high until reset, and the inputs keep flowing.
- R9: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` does not change.
- R10: Reset clears the byte totals, the pending events, the queue and `overflow`. After reset, `rec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 6 | One beat-valid bit per stream |
| s_keep | input | 48 | Byte strobes, 8 per stream, stream s in bits s*8+7:s*8 |
| s_ready | output | 6 | Always-ready indication per stream |
| rec_valid | output | 1 | A record is available |
| rec_data | output | 32 | Record: stream number [31:29], timestamp [28:0] |
| rec_ready | input | 1 | Consumer accepts the record |
| overflow | output | 1 | Sticky flag: at least one event was lost |

## Verification
The bench builds the block with its defaults: six streams, 8-byte beats, 1024-byte blocks and a 16-entry queue. With 8-byte beats a stream needs at least 128 beats per block, and strobe patterns chosen at random make the remainder carry happen on almost every block. The 16-entry queue fills in about two thousand cycles of one busy stream while the reader is held off, so the drop path and the sticky flag can be reached. The per-stream pending registers make it possible to force three streams to complete in the same cycle and then observe the order and stamps of the merged records.

// File: rtl/pkt_stamp_pkg.sv
package pkt_stamp_pkg;

  // Bytes delivered by one beat: set strobes, or none when the beat is not valid.
  function automatic int unsigned beat_bytes(input logic vld, input logic [63:0] strobes);
    return vld ? int'($countones(strobes)) : 0;
  endfunction

  // True when the running total reaches a block boundary.
  function automatic logic block_reached(input int unsigned fill, input int unsigned add,
                                         input int unsigned blk);
    return (fill + add) >= blk;
  endfunction

  // Running total after a beat, remainder carried past a boundary.
  function automatic int unsigned fill_after(input int unsigned fill, input int unsigned add,
                                             input int unsigned blk);
    return ((fill + add) >= blk) ? (fill + add - blk) : (fill + add);
  endfunction

endpackage

// File: rtl/stream_block_counter.sv
module stream_block_counter #(
  parameter int BEAT_BYTES  = 8,
  parameter int BLOCK_BYTES = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat_valid,
  input  logic [BEAT_BYTES-1:0] beat_keep,
  output logic                  block_done
);
  import pkt_stamp_pkg::*;
  localparam int CNT_W = $clog2(BLOCK_BYTES);

  logic [CNT_W-1:0] fill_q;
  int unsigned      add_c;
  int unsigned      next_c;

  always_comb begin
    add_c      = beat_bytes(beat_valid, 64'(beat_keep));
    block_done = block_reached(32'(fill_q), add_c, BLOCK_BYTES);
    next_c     = fill_after(32'(fill_q), add_c, BLOCK_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= CNT_W'(next_c);
  end

  // R4 R3: an event only ever comes from an accepted beat
  fire_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> beat_valid);
  // R4: a beat smaller than a block cannot complete two blocks back to back
  fire_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done || (BEAT_BYTES * 2 > BLOCK_BYTES));

endmodule

// File: rtl/stamp_arbiter.sv
module stamp_arbiter #(
  parameter int NS   = 6,
  parameter int ID_W = 3,
  parameter int TS_W = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   fire,
  input  logic [TS_W-1:0] ts_now,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_id,
  output logic [TS_W-1:0] wr_ts,
  output logic            pend_drop
);
  logic [NS-1:0]   pend_v;
  logic [TS_W-1:0] pend_ts [NS];
  logic [NS-1:0]   grant;

  always_comb begin
    grant = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend_v[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
    wr_en = |pend_v;
    wr_id = '0;
    wr_ts = '0;
    for (int i = 0; i < NS; i++) begin
      if (grant[i]) wr_id = ID_W'(i);
      wr_ts = wr_ts | (pend_ts[i] & {TS_W{grant[i]}});
    end
    pend_drop = |(fire & pend_v & ~grant);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= '0;
      for (int i = 0; i < NS; i++) pend_ts[i] <= '0;
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (fire[i] && !(pend_v[i] && !grant[i])) begin
          pend_v[i]  <= 1'b1;
          pend_ts[i] <= ts_now;
        end else if (grant[i]) begin
          pend_v[i] <= 1'b0;
        end
      end
    end
  end

  // R6: exactly one stream is served whenever a record is written
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(grant));
  // R6: a served stream's pending slot empties unless refilled the same cycle
  grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|(fire & grant))) |=> $countones(pend_v) < $countones($past(pend_v)) + $countones($past(fire)));

endmodule

// File: rtl/record_fifo.sv
module record_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  always_comb begin
    full      = (count == (AW+1)'(DEPTH));
    out_valid = (count != '0);
    out_data  = mem[rd_ptr];
    do_push   = push && !full;
    do_pop    = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R8: occupancy never passes the depth
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  // R7: an accepted write is visible on the output side next cycle
  fifo_push_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> out_valid);

endmodule

// File: rtl/pkt_stamp_logger.sv
module pkt_stamp_logger #(
  parameter int N_STREAMS   = 6,
  parameter int BEAT_BYTES  = 8,
  parameter int BLOCK_BYTES = 1024,
  parameter int REC_W       = 32,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_STREAMS-1:0]            s_valid,
  input  logic [N_STREAMS*BEAT_BYTES-1:0] s_keep,
  output logic [N_STREAMS-1:0]            s_ready,
  output logic                            rec_valid,
  output logic [REC_W-1:0]                rec_data,
  input  logic                            rec_ready,
  output logic                            overflow
);
  localparam int ID_W = $clog2(N_STREAMS);
  localparam int TS_W = REC_W - ID_W;

  logic [TS_W-1:0]      ts;
  logic [N_STREAMS-1:0] fire;
  logic                 wr_en;
  logic [ID_W-1:0]      wr_id;
  logic [TS_W-1:0]      wr_ts;
  logic                 pend_drop;
  logic                 fifo_full;
  logic                 rec_drop;

  assign s_ready = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_lane
    stream_block_counter #(
      .BEAT_BYTES (BEAT_BYTES),
      .BLOCK_BYTES(BLOCK_BYTES)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_valid(s_valid[g]),
      .beat_keep (s_keep[g*BEAT_BYTES +: BEAT_BYTES]),
      .block_done(fire[g])
    );
  end

  stamp_arbiter #(
    .NS  (N_STREAMS),
    .ID_W(ID_W),
    .TS_W(TS_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .ts_now   (ts),
    .wr_en    (wr_en),
    .wr_id    (wr_id),
    .wr_ts    (wr_ts),
    .pend_drop(pend_drop)
  );

  record_fifo #(
    .W    (REC_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_en),
    .push_data({wr_id, wr_ts}),
    .full     (fifo_full),
    .out_valid(rec_valid),
    .out_data (rec_data),
    .out_ready(rec_ready)
  );

  assign rec_drop = (wr_en && fifo_full) || pend_drop;

  always_ff @(posedge clk) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (rec_drop) overflow <= 1'b1;
  end

  // R1
  ready_const_chk: assert property (@(posedge clk) s_ready == '1);
  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts == TS_W'($past(ts) + 1'b1));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);
  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(rec_drop));
  // R9
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

endmodule

// File: tb/tb_pkt_stamp_logger.sv
`timescale 1ns/1ps
module tb_pkt_stamp_logger;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int BB = 8;
  localparam int BLK = 1024;
  localparam int DEPTH = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     s_valid = '0;
  logic [NS*BB-1:0]  s_keep = '0;
  logic [NS-1:0]     s_ready;
  logic              rec_valid;
  logic [31:0]       rec_data;
  logic              rec_ready = 1'b1;
  logic              overflow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [28:0] bts;
  int          fill [NS];
  logic [31:0] expq [$];
  logic [31:0] gotlog [$];
  bit          capped = 0;
  int          cap_pushes = 0;
  int          pops = 0;

  pkt_stamp_logger dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_keep(s_keep), .s_ready(s_ready),
    .rec_valid(rec_valid), .rec_data(rec_data), .rec_ready(rec_ready), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bts <= '0;
    else        bts <= bts + 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one beat per call on the chosen streams; model the expected records.
  task automatic step(input logic [NS-1:0] v, input logic [NS*BB-1:0] k);
    @(negedge clk);
    s_valid = v;
    s_keep  = k;
    for (int s = 0; s < NS; s++) begin
      if (v[s]) begin
        fill[s] += $countones(k[s*BB +: BB]);
        if (fill[s] >= BLK) begin
          fill[s] -= BLK;
          if (!capped || cap_pushes < DEPTH) expq.push_back({3'(s), bts});
          if (capped) cap_pushes++;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, {$urandom, $urandom});
  endtask

  task automatic bring_to(input int s, input int target);
    int need;
    need = (target - fill[s] + BLK) % BLK;
    while (need >= BB) begin
      step(NS'(1) << s, {$urandom, $urandom} | ({{(NS*BB-BB){1'b0}}, {BB{1'b1}}} << (s*BB)));
      need -= BB;
    end
    if (need > 0) begin
      logic [NS*BB-1:0] k;
      k = {$urandom, $urandom};
      k[s*BB +: BB] = BB'((1 << need) - 1);
      step(NS'(1) << s, k);
    end
  endtask

  // Monitor: samples mid-cycle, the handshake completes at the next edge.
  always begin
    @(negedge clk);
    #2;
    if (rst_n && rec_valid && rec_ready) begin
      bit hit;
      hit = 0;
      pops++;
      gotlog.push_back(rec_data);
      for (int i = 0; i < expq.size(); i++) begin
        if (expq[i][31:29] == rec_data[31:29]) begin
          check(expq[i] == rec_data, "R5 R7 record", rec_data, expq[i]);
          expq.delete(i);
          hit = 1;
          break;
        end
      end
      if (!hit) check(0, "R7 unexpected record", rec_data, 32'h0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) fill[s] = 0;
    repeat (4) @(negedge clk);
    #2;
    // R10 reset state, R1 ready
    check(rec_valid == 1'b0, "R10 rec_valid in reset", 32'(rec_valid), 0);
    check(overflow == 1'b0, "R10 overflow in reset", 32'(overflow), 0);
    check(s_ready == '1, "R1 ready", 32'(s_ready), 32'h3f);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 strobes with valid low are ignored
    idle(300);
    check(pops == 0, "R3 idle strobes ignored", pops, 0);

    // R4 exact boundary with carry: 1020 then 8 bytes -> one event, remainder 4
    bring_to(1, 1020);
    step(6'b000010, {NS*BB{1'b1}});
    idle(6);
    check(pops == 1, "R4 boundary event", pops, 1);
    check(fill[1] == 4, "R4 remainder model", fill[1], 4);
    bring_to(1, 1023);
    step(6'b000010, {NS*BB{1'b1}} & 48'h0000_0000_0100);
    idle(6);
    check(pops == 2, "R4 carried remainder completes", pops, 2);

    // Random traffic on all streams with random reader stalls (R3 R4 R5 R7 R9)
    for (int c = 0; c < 5000; c++) begin
      rec_ready = ($urandom % 4) != 0;
      step(NS'($urandom), {$urandom, $urandom});
    end
    rec_ready = 1'b1;
    idle(40);
    check(expq.size() == 0, "R7 all records delivered", expq.size(), 0);
    check(overflow == 1'b0, "R8 no overflow under load", 32'(overflow), 0);

    // R6 simultaneous completion on streams 0, 2 and 5
    bring_to(0, 1016);
    bring_to(2, 1016);
    bring_to(5, 1016);
    idle(20);
    gotlog.delete();
    step(6'b100101, {NS*BB{1'b1}});
    idle(10);
    check(gotlog.size() == 3, "R6 three records", gotlog.size(), 3);
    if (gotlog.size() == 3) begin
      check(gotlog[0][31:29] == 3'd0, "R6 first id", 32'(gotlog[0][31:29]), 0);
      check(gotlog[1][31:29] == 3'd2, "R6 second id", 32'(gotlog[1][31:29]), 2);
      check(gotlog[2][31:29] == 3'd5, "R6 third id", 32'(gotlog[2][31:29]), 5);
      check(gotlog[0][28:0] == gotlog[2][28:0], "R6 shared capture time", gotlog[2], gotlog[0]);
    end

    // R8 overflow: reader held off, 20 events on stream 0, only 16 kept
    rec_ready = 1'b0;
    capped = 1;
    cap_pushes = 0;
    pops = 0;
    while (cap_pushes < 20) step(6'b000001, {NS*BB{1'b1}});
    idle(10);
    check(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
    begin
      logic [31:0] held;
      held = rec_data;
      idle(5);
      check(rec_valid && rec_data == held, "R9 hold under stall", rec_data, held);
    end
    rec_ready = 1'b1;
    idle(40);
    check(pops == DEPTH, "R8 records kept", pops, DEPTH);
    check(expq.size() == 0, "R8 kept records match", expq.size(), 0);
    check(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);

    // R10 reset clears flag
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check(overflow == 1'b0, "R10 overflow cleared", 32'(overflow), 0);
    check(rec_valid == 1'b0, "R10 queue cleared", 32'(rec_valid), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule